// File: doc/BRIEF.md
# Clock-Enable Control Register Slave on a Two-Wire Serial Bus

This block sits on a two-wire serial bus as a slave and owns a small bank of byte-wide clock-enable control registers. A bus master reaches the bank with one fixed 7-bit device address. The block samples the bus clock and data lines in the system clock domain through a short synchronizer. It finds start and stop conditions by edge detection and acknowledges each byte it accepts by pulling the data line low through an open-drain enable.

A write transfer carries three leading bytes: the address byte, a command byte and a count byte. The block acknowledges the command and count bytes but does not use their contents. Each data byte after them lands in the next register, starting from register 0. The transfer ends at the stop condition. To change a register, the master must therefore also resend every register below it. Bytes past the last register are acknowledged and dropped.

A read transfer returns the number of registers first, then the register contents from register 0 upward. It ends when the master answers a byte with NACK. Every register takes a default on reset, so a system that never talks to the bus still sees all clocks enabled. The register bank drives a flat parallel output bus. All pins are plain level signals; no data passes through a valid/ready handshake, so the block has no back-pressure rules.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: After reset every register reads 0xFF and `sda_oe` is 0, leaving the data line released.
- R2: An address byte of 0xD2 (device address 0x69 in bits 7:1, bit 0 = 0 for write) is acknowledged: `sda_oe` pulls the line low during the ninth clock of that byte.
- R3: An address byte whose bits 7:1 differ from 0x69 gets no acknowledge, and the block ignores every later byte until the next start condition. Registers stay unchanged.
- R4: In a write, the two bytes after the address (command, then count) are each acknowledged, and their values never reach any register.
- R5: In a write, data byte k (k = 0, 1, ...) after the count byte is stored in register k. Register k sits at bits 8k+7:8k of `ctrl_regs`.
- R6: In a write, data bytes beyond register NREG-1 are acknowledged and discarded. No register changes because of them.
- R7: A stop condition ends the transfer. The next write again begins at register 0.
- R8: An address byte of 0xD3 (bit 0 = 1 for read) is acknowledged. The block then sends the byte count NREG (6), followed by registers 0, 1, ... MSB first. After the last register it sends 0x00.
- R9: When the master answers a read byte with NACK, the block releases the data line and drives nothing more until the next start.
- R10: `sda_oe` changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the bus bit rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| ctrl_regs | output | NREG*8 | Register bank, register k at bits 8k+7:8k |

## Verification
The hardest states to reach from the ports are the ones at the end of a transfer. One is a write that runs past the last register. Another is a read that overruns the bank or stops early on a NACK. A third is the quiet period after a foreign address, where the bus still carries traffic. The bench reaches each one with a separate directed bus sequence. It sends eight data bytes into a six-register bank, reads all seven bytes and one more, and reads two bytes before a NACK. It also keeps clocking bytes after a wrong address and then recovers with a repeated start. A monitor on `sda_oe` watches every bus cycle for a change while the clock line is high.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_RACK
  } bus_state_e;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_CNT,
    PH_DATA
  } wr_phase_e;
endpackage

// File: rtl/i2c_pin_sync.sv
module i2c_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_prev;
  logic              sda_prev;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= 1'b1;
          sda_chain <= 1'b1;
        end else begin
          scl_chain <= scl_i;
          sda_chain <= sda_i;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_i};
          sda_chain <= {sda_chain[STAGES-2:0], sda_i};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_chain[STAGES-1];
      sda_prev <= sda_chain[STAGES-1];
    end
  end

  assign scl_lvl   = scl_chain[STAGES-1];
  assign sda_lvl   = sda_chain[STAGES-1];
  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/ctl_regfile.sv
module ctl_regfile #(
  parameter int         NREG    = 6,
  parameter logic [7:0] DEFAULT = 8'hFF,
  parameter int         PW      = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PW-1:0]     wr_sel,
  input  logic [7:0]        wr_data,
  input  logic [PW-1:0]     rd_sel,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);
  logic [7:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bank[g] <= DEFAULT;
      end else if (wr_en && (wr_sel == PW'(g))) begin
        bank[g] <= wr_data;
      end
    end
    assign regs_flat[g*8 +: 8] = bank[g];
  end

  always_comb begin
    rd_data = 8'h00;
    for (int i = 0; i < NREG; i++) begin
      if (rd_sel == PW'(i)) rd_data = bank[i];
    end
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import ctlreg_pkg::*;
#(
  parameter int         NREG     = 6,
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         PW       = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  output logic          sda_oe,
  output logic          wr_en,
  output logic [PW-1:0] wr_sel,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] rd_sel,
  input  logic [7:0]    rd_data,
  output logic          idle,
  output logic          data_phase
);
  bus_state_e    st;
  wr_phase_e     phase;
  logic [7:0]    rx_sh;
  logic [3:0]    rx_cnt;
  logic [7:0]    tx_sh;
  logic [2:0]    tx_cnt;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] tx_idx;
  logic          is_rd;
  logic          m_nack;
  logic [7:0]    tx_next;
  logic          byte_done;

  localparam logic [PW-1:0] LAST_RD = PW'(NREG + 1);
  localparam logic [PW-1:0] REG_END = PW'(NREG);

  assign byte_done  = (st == ST_RX) && scl_fall && (rx_cnt == 4'd8);
  assign wr_en      = byte_done && (phase == PH_DATA) && (wr_ptr < REG_END);
  assign wr_sel     = wr_ptr;
  assign wr_data    = rx_sh;
  assign rd_sel     = tx_idx - PW'(1);
  assign idle       = (st == ST_IDLE);
  assign data_phase = (phase == PH_DATA);

  always_comb begin
    if (tx_idx == '0)            tx_next = 8'(NREG);
    else if (tx_idx <= REG_END)  tx_next = rd_data;
    else                         tx_next = 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      phase  <= PH_ADDR;
      rx_sh  <= '0;
      rx_cnt <= '0;
      tx_sh  <= '0;
      tx_cnt <= '0;
      wr_ptr <= '0;
      tx_idx <= '0;
      is_rd  <= 1'b0;
      m_nack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (start_det) begin
      st     <= ST_RX;
      phase  <= PH_ADDR;
      rx_cnt <= '0;
      wr_ptr <= '0;
      tx_idx <= '0;
      is_rd  <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RX: begin
          if (scl_rise) begin
            rx_sh  <= {rx_sh[6:0], sda_lvl};
            rx_cnt <= rx_cnt + 4'd1;
          end else if (byte_done) begin
            if (phase == PH_ADDR && rx_sh[7:1] != DEV_ADDR) begin
              st <= ST_IDLE;
            end else begin
              sda_oe <= 1'b1;
              st     <= ST_ACK;
              if (phase == PH_ADDR) is_rd <= rx_sh[0];
              if (phase == PH_DATA && wr_ptr < REG_END) wr_ptr <= wr_ptr + PW'(1);
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            rx_cnt <= '0;
            if (phase != PH_DATA) phase <= wr_phase_e'(phase + 2'd1);
            if (is_rd) begin
              tx_sh  <= tx_next;
              sda_oe <= ~tx_next[7];
              tx_cnt <= '0;
              if (tx_idx < LAST_RD) tx_idx <= tx_idx + PW'(1);
              st     <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (tx_cnt == 3'd7) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              tx_sh  <= {tx_sh[6:0], 1'b0};
              sda_oe <= ~tx_sh[6];
              tx_cnt <= tx_cnt + 3'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            m_nack <= sda_lvl;
          end else if (scl_fall) begin
            if (!m_nack) begin
              tx_sh  <= tx_next;
              sda_oe <= ~tx_next[7];
              tx_cnt <= '0;
              if (tx_idx < LAST_RD) tx_idx <= tx_idx + PW'(1);
              st     <= ST_TX;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave #(
  parameter int         NREG        = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter logic [7:0] DEFAULT     = 8'hFF,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] ctrl_regs
);
  localparam int PW = $clog2(NREG + 2);

  logic          scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en, eng_idle, eng_data_phase;
  logic [PW-1:0] wr_sel, rd_sel;
  logic [7:0]    wr_data, rd_data;

  i2c_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_slave_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR), .PW(PW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data),
    .idle      (eng_idle),
    .data_phase(eng_data_phase)
  );

  ctl_regfile #(.NREG(NREG), .DEFAULT(DEFAULT), .PW(PW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .regs_flat(ctrl_regs)
  );
endmodule

// File: rtl/clkctl_i2c_chk.sv
module clkctl_i2c_chk #(
  parameter int NREG = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_lvl,
  input logic              stop_det,
  input logic              sda_oe,
  input logic              in_idle,
  input logic              data_phase,
  input logic [NREG*8-1:0] regs
);
  // R10: the pull-down only moves while the synchronized clock line is low
  assert_oe_moves_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_lvl);

  // R3 and R9: an idle slave never pulls the line
  assert_idle_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> !sda_oe);

  // R4: registers change only once the data phase of a write is reached
  assert_regs_only_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(regs) |-> $past(data_phase));

  // R7: a stop condition returns the engine to idle
  assert_stop_to_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> in_idle);
endmodule

bind clkctl_i2c_slave clkctl_i2c_chk #(.NREG(NREG)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_lvl   (scl_lvl),
  .stop_det  (stop_det),
  .sda_oe    (sda_oe),
  .in_idle   (eng_idle),
  .data_phase(eng_data_phase),
  .regs      (ctrl_regs)
);

// File: tb/tb_clkctl_i2c_slave.sv
`timescale 1ns/1ps
module tb_clkctl_i2c_slave;
  localparam int NREG = 6;
  localparam int Q    = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe;
  logic sda_line;
  logic [NREG*8-1:0] ctrl_regs;
  logic [7:0] exp_reg [NREG];
  int   n_run = 0;
  int   n_fail = 0;
  int   oe_bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  clkctl_i2c_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .ctrl_regs(ctrl_regs)
  );

  always @(sda_oe) if (rst_n && scl_m) oe_bad++;

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < NREG; i++)
      check(req, $sformatf("reg%0d", i), int'(ctrl_regs[i*8 +: 8]), int'(exp_reg[i]));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    ack = sda_line;
    wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(input logic nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); scl_m = 1'b1; wq(Q); b[i] = sda_line; wq(Q); scl_m = 1'b0;
    end
    sda_m = nack; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    check_regs("R1");
    check("R1", "sda_oe after reset", int'(sda_oe), 0);
  endtask

  task automatic t_write_partial();
    logic a;
    logic [7:0] d [3] = '{8'h12, 8'h34, 8'h56};
    bus_start();
    send_byte(8'hD2, a); check("R2", "ack on 0xD2", int'(a), 0);
    send_byte(8'h00, a); check("R4", "ack on command", int'(a), 0);
    send_byte(8'h03, a); check("R4", "ack on count", int'(a), 0);
    for (int i = 0; i < 3; i++) begin
      send_byte(d[i], a); check("R5", "ack on data", int'(a), 0);
      exp_reg[i] = d[i];
    end
    bus_stop();
    check_regs("R5");
  endtask

  task automatic t_header_only();
    logic a;
    bus_start();
    send_byte(8'hD2, a);
    send_byte(8'hA5, a); check("R4", "ack on command 0xA5", int'(a), 0);
    send_byte(8'h3C, a); check("R4", "ack on count 0x3C", int'(a), 0);
    bus_stop();
    check_regs("R4");
  endtask

  task automatic t_write_overrun();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h08, a);
    for (int i = 0; i < 8; i++) begin
      send_byte(8'(8'hA0 + i), a);
      if (i < NREG) exp_reg[i] = 8'(8'hA0 + i);
      else check("R6", "ack on surplus byte", int'(a), 0);
    end
    bus_stop();
    check_regs("R6");
  endtask

  task automatic t_restart_at_zero();
    logic a;
    bus_start();
    send_byte(8'hD2, a); send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h5E, a); exp_reg[0] = 8'h5E;
    bus_stop();
    check_regs("R7");
    check("R7", "sda_oe after stop", int'(sda_oe), 0);
  endtask

  task automatic t_read_all();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a); check("R8", "ack on 0xD3", int'(a), 0);
    recv_byte(1'b0, b); check("R8", "byte count", int'(b), NREG);
    for (int i = 0; i < NREG; i++) begin
      recv_byte(1'b0, b); check("R8", $sformatf("read reg%0d", i), int'(b), int'(exp_reg[i]));
    end
    recv_byte(1'b1, b); check("R8", "past last reg", int'(b), 0);
    wq(Q);
    check("R9", "release after NACK", int'(sda_oe), 0);
    bus_stop();
    check_regs("R8");
  endtask

  task automatic t_read_short();
    logic a;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, a);
    recv_byte(1'b0, b);
    recv_byte(1'b1, b); check("R8", "short read reg0", int'(b), int'(exp_reg[0]));
    recv_byte(1'b1, b); check("R9", "line idle after NACK", int'(b), 8'hFF);
    check("R9", "sda_oe after NACK", int'(sda_oe), 0);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    send_byte(8'hA4, a); check("R3", "no ack on 0xA4", int'(a), 1);
    send_byte(8'h00, a); check("R3", "no ack after mismatch", int'(a), 1);
    send_byte(8'h02, a);
    send_byte(8'h11, a); check("R3", "no ack on data after mismatch", int'(a), 1);
    check_regs("R3");
    bus_start();
    send_byte(8'hD5, a); check("R3", "no ack on 0xD5", int'(a), 1);
    bus_start();
    send_byte(8'hD2, a); check("R3", "ack after repeated start", int'(a), 0);
    send_byte(8'h00, a); send_byte(8'h01, a);
    send_byte(8'h77, a); exp_reg[0] = 8'h77;
    bus_stop();
    check_regs("R3");
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) exp_reg[i] = 8'hFF;
    wq(5);
    rst_n = 1'b1;
    wq(5);
    t_reset();
    t_write_partial();
    t_header_only();
    t_write_overrun();
    t_restart_at_zero();
    t_read_all();
    t_read_short();
    t_wrong_addr();
    check("R10", "sda_oe changes while SCL high", oe_bad, 0);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule